// File: doc/BRIEF.md
# Boot Memory Alias Selector

The block decides which memory appears at address zero once the device leaves reset. There are three choices: flash, system memory and SRAM. The choice comes either from an external boot pin or from a stored option bit. A separate option bit selects which of the two is used, and a third option bit chooses between system memory and SRAM.

The configuration is not taken when reset is released. It is captured on a fixed clock edge after release, and captured again each time the device wakes from standby. A persistent empty-device flag covers unprogrammed parts: while it is set, a boot that resolves to flash is sent to system memory instead. The flag is updated only when the option bytes are loaded, and only power-on reset clears it.

After start-up, software can move the alias to another memory through a remap write. A parameter selects a variant in which the boot pin is shared with a GPIO. In that variant the pin level is captured only on the first edge after reset, and that stored value is used for every later capture.

Top module: `boot_alias_ctrl`

## Requirements
- R1: `sel_o` encodes flash as 2'b00, system memory as 2'b01 and SRAM as 2'b11, and never shows 2'b10.
- R2: With `opt_use_bit_i`=0, a pin level of 0 selects flash. A pin level of 1 selects system memory when `opt_sys_n_i`=1 and SRAM when `opt_sys_n_i`=0.
- R3: With `opt_use_bit_i`=1, the pin is ignored. `opt_boot_n_i`=1 selects flash. `opt_boot_n_i`=0 selects system memory when `opt_sys_n_i`=1 and SRAM when `opt_sys_n_i`=0.
- R4: After `rst_ni` rises, `sel_o` stays 2'b00 through the first rising clock edge. The configuration present at the second rising edge appears on `sel_o` right after that edge.
- R5: After start-up, a clock edge that samples `stby_exit_i`=1 captures the current configuration. This capture takes priority over a remap write in the same cycle.
- R6: With PIN_AT_RST=1, the pin level sampled on the first edge after reset is the one used in the start-up capture and in every standby-exit capture until the next reset.
- R7: On an edge with `opt_load_i`=1, `empty_o` becomes 1 if `flash_word0_i` is zero and 0 otherwise. At all other times it holds, including across `rst_ni`. Only `por_ni` clears it.
- R8: If `empty_o` is 1 at a capture and the selection resolves to flash, system memory is selected instead.
- R9: After start-up, `remap_we_i` loads `remap_sel_i` into `sel_o` on the next edge. The value 2'b10 is ignored, and writes before start-up completes are ignored.
- R10: `rst_ni` low forces `sel_o` to 2'b00 at once and restarts the start-up sequence.
- R11: With no capture and no accepted remap, `sel_o` holds even while the pin, the option bits or the empty flag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| por_ni | input | 1 | Asynchronous active-low power-on reset, clears the empty flag |
| pin_boot_i | input | 1 | Boot pin level |
| opt_use_bit_i | input | 1 | 1: use option bit instead of pin |
| opt_sys_n_i | input | 1 | 1: system memory, 0: SRAM for the non-flash choice |
| opt_boot_n_i | input | 1 | Option boot bit, 1 selects flash |
| opt_load_i | input | 1 | Option byte load strobe |
| flash_word0_i | input | WORD_W | First flash word, read during option load |
| stby_exit_i | input | 1 | Standby exit event |
| remap_we_i | input | 1 | Software remap write |
| remap_sel_i | input | 2 | Software remap value |
| sel_o | output | 2 | Memory aliased at address zero |
| empty_o | output | 1 | Empty-device flag |

## Verification
Each result has a fixed due cycle, measured from the edge where its stimulus is first seen. A remap or standby capture shows on `sel_o` after the edge that samples it. An option load shows on `empty_o` after its edge. The start-up capture shows only after the second edge following reset release. The bench drives inputs at the falling edge and compares at the falling edge that follows each due edge, so the value one edge too early is also checked (still 2'b00 at start-up). Two instances, one of each pin variant, receive identical stimulus, and the pin is changed between the first and second edges so that the two variants must disagree.

// File: rtl/boot_alias_pkg.sv
package boot_alias_pkg;
  typedef enum logic [1:0] {
    SEL_FLASH = 2'b00,
    SEL_SYS   = 2'b01,
    SEL_RSV   = 2'b10,
    SEL_SRAM  = 2'b11
  } boot_sel_e;
endpackage

// File: rtl/boot_alias_seq.sv
module boot_alias_seq #(
  parameter int CAP_EDGE = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic pin_stb_o,
  output logic cfg_stb_o,
  output logic done_o
);
  localparam int CW = $clog2(CAP_EDGE + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end

  assign pin_stb_o = (cnt_q == '0);
  assign cfg_stb_o = (cnt_q == CW'(CAP_EDGE - 1));
  assign done_o    = (cnt_q == CW'(CAP_EDGE));
endmodule

// File: rtl/boot_alias_decode.sv
module boot_alias_decode
  import boot_alias_pkg::*;
(
  input  logic      pin_i,
  input  logic      use_bit_i,
  input  logic      sys_n_i,
  input  logic      boot_n_i,
  input  logic      empty_i,
  output boot_sel_e sel_o
);
  logic flash_req;
  always_comb begin
    flash_req = use_bit_i ? boot_n_i : !pin_i;
    if (flash_req) sel_o = empty_i ? SEL_SYS : SEL_FLASH;
    else           sel_o = sys_n_i ? SEL_SYS : SEL_SRAM;
  end
endmodule

// File: rtl/boot_alias_empty.sv
module boot_alias_empty #(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              flag_o
);
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)     flag_o <= 1'b0;
    else if (load_i) flag_o <= (word_i == '0);
  end
endmodule

// File: rtl/boot_alias_ctrl.sv
module boot_alias_ctrl
  import boot_alias_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int CAP_EDGE   = 2,
  parameter bit PIN_AT_RST = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              pin_boot_i,
  input  logic              opt_use_bit_i,
  input  logic              opt_sys_n_i,
  input  logic              opt_boot_n_i,
  input  logic              opt_load_i,
  input  logic [WORD_W-1:0] flash_word0_i,
  input  logic              stby_exit_i,
  input  logic              remap_we_i,
  input  logic [1:0]        remap_sel_i,
  output logic [1:0]        sel_o,
  output logic              empty_o
);
  logic      pin_stb, cfg_stb, boot_done;
  logic      pin_q, pin_use;
  boot_sel_e dec_sel, sel_q;

  boot_alias_seq #(.CAP_EDGE(CAP_EDGE)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_stb_o(pin_stb),
    .cfg_stb_o(cfg_stb),
    .done_o   (boot_done)
  );

  boot_alias_empty #(.WORD_W(WORD_W)) u_empty (
    .clk_i (clk_i),
    .por_ni(por_ni),
    .load_i(opt_load_i),
    .word_i(flash_word0_i),
    .flag_o(empty_o)
  );

  // shared-pin variant keeps the level seen on the first edge after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pin_q <= 1'b0;
    else if (pin_stb) pin_q <= pin_boot_i;
  end
  assign pin_use = PIN_AT_RST ? pin_q : pin_boot_i;

  boot_alias_decode u_dec (
    .pin_i    (pin_use),
    .use_bit_i(opt_use_bit_i),
    .sys_n_i  (opt_sys_n_i),
    .boot_n_i (opt_boot_n_i),
    .empty_i  (empty_o),
    .sel_o    (dec_sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      sel_q <= SEL_FLASH;
    else if (cfg_stb || (boot_done && stby_exit_i))
      sel_q <= dec_sel;
    else if (boot_done && remap_we_i && (remap_sel_i != SEL_RSV))
      sel_q <= boot_sel_e'(remap_sel_i);
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/boot_alias_chk.sv
module boot_alias_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              por_ni,
  input logic              opt_load_i,
  input logic [WORD_W-1:0] flash_word0_i,
  input logic              stby_exit_i,
  input logic              remap_we_i,
  input logic [1:0]        remap_sel_i,
  input logic [1:0]        sel_o,
  input logic              empty_o,
  input logic              boot_done
);
  AST_SEL_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o != 2'b10); // R1
  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boot_done && !stby_exit_i && !remap_we_i) |=> $stable(sel_o)); // R11
  AST_REMAP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boot_done && remap_we_i && !stby_exit_i && remap_sel_i != 2'b10)
      |=> sel_o == $past(remap_sel_i)); // R9
  AST_EMPTY_SET: assert property (@(posedge clk_i) disable iff (!por_ni)
    (opt_load_i && flash_word0_i == '0) |=> empty_o); // R7
  AST_EMPTY_HOLD: assert property (@(posedge clk_i) disable iff (!por_ni)
    !opt_load_i |=> $stable(empty_o)); // R7
  AST_EMPTY_NO_FLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boot_done && stby_exit_i && empty_o && !opt_load_i) |=> sel_o != 2'b00); // R8
endmodule

bind boot_alias_ctrl boot_alias_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .por_ni       (por_ni),
  .opt_load_i   (opt_load_i),
  .flash_word0_i(flash_word0_i),
  .stby_exit_i  (stby_exit_i),
  .remap_we_i   (remap_we_i),
  .remap_sel_i  (remap_sel_i),
  .sel_o        (sel_o),
  .empty_o      (empty_o),
  .boot_done    (boot_done)
);

// File: tb/boot_alias_ctrl_test.sv
module boot_alias_ctrl_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_ni = 1'b0, por_ni = 1'b0;
  logic        pin = 1'b0, use_bit = 1'b0, sys_n = 1'b1, boot_n = 1'b1;
  logic        opt_load = 1'b0, stby = 1'b0, remap_we = 1'b0;
  logic [31:0] word0 = 32'h1;
  logic [1:0]  remap_sel = 2'b00;
  logic [1:0]  sel_std, sel_shr;
  logic        empty_std, empty_shr;

  int n_cmp = 0, n_bad = 0;
  logic       empty_m = 1'b0, pin_rst = 1'b0;
  logic [1:0] cur_std = 2'b00, cur_shr = 2'b00;

  boot_alias_ctrl #(.PIN_AT_RST(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .por_ni(por_ni), .pin_boot_i(pin),
    .opt_use_bit_i(use_bit), .opt_sys_n_i(sys_n), .opt_boot_n_i(boot_n),
    .opt_load_i(opt_load), .flash_word0_i(word0), .stby_exit_i(stby),
    .remap_we_i(remap_we), .remap_sel_i(remap_sel), .sel_o(sel_std), .empty_o(empty_std));

  boot_alias_ctrl #(.PIN_AT_RST(1'b1)) uut_shr (
    .clk_i(clk), .rst_ni(rst_ni), .por_ni(por_ni), .pin_boot_i(pin),
    .opt_use_bit_i(use_bit), .opt_sys_n_i(sys_n), .opt_boot_n_i(boot_n),
    .opt_load_i(opt_load), .flash_word0_i(word0), .stby_exit_i(stby),
    .remap_we_i(remap_we), .remap_sel_i(remap_sel), .sel_o(sel_shr), .empty_o(empty_shr));

  function automatic logic [1:0] exp_sel(logic p, logic ub, logic sn, logic bn, logic em);
    logic fl;
    fl = ub ? bn : !p;
    if (fl) return em ? 2'b01 : 2'b00;
    return sn ? 2'b01 : 2'b11;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic load_opt(logic [31:0] w);
    @(negedge clk); opt_load = 1'b1; word0 = w;
    @(negedge clk); opt_load = 1'b0;
    empty_m = (w == 32'h0);
    chk("R7 empty std", {31'b0, empty_std}, {31'b0, empty_m});
    chk("R7 empty shr", {31'b0, empty_shr}, {31'b0, empty_m});
  endtask

  task automatic boot(logic p1, logic p2, logic ub, logic sn, logic bn);
    @(negedge clk);
    rst_ni = 1'b0; remap_we = 1'b1; remap_sel = 2'b11;
    @(negedge clk);
    chk("R10 reset std", {30'b0, sel_std}, 32'h0);
    chk("R10 reset shr", {30'b0, sel_shr}, 32'h0);
    chk("R7 empty kept over reset", {31'b0, empty_std}, {31'b0, empty_m});
    pin = p1; use_bit = ub; sys_n = sn; boot_n = bn;
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R4 first edge std", {30'b0, sel_std}, 32'h0);
    chk("R9 early remap ignored", {30'b0, sel_shr}, 32'h0);
    remap_we = 1'b0; pin = p2;
    @(negedge clk);
    pin_rst = p1;
    cur_std = exp_sel(p2, ub, sn, bn, empty_m);
    cur_shr = exp_sel(p1, ub, sn, bn, empty_m);
    chk(ub ? "R3 R4 std" : "R2 R4 R8 std", {30'b0, sel_std}, {30'b0, cur_std});
    chk("R6 shr pin at reset", {30'b0, sel_shr}, {30'b0, cur_shr});
  endtask

  task automatic remap(logic [1:0] v);
    @(negedge clk); remap_we = 1'b1; remap_sel = v;
    @(negedge clk); remap_we = 1'b0;
    if (v != 2'b10) begin cur_std = v; cur_shr = v; end
    chk("R9 R1 remap std", {30'b0, sel_std}, {30'b0, cur_std});
    chk("R9 R1 remap shr", {30'b0, sel_shr}, {30'b0, cur_shr});
  endtask

  task automatic stby_exit(logic p, logic ub, logic sn, logic bn);
    @(negedge clk);
    pin = p; use_bit = ub; sys_n = sn; boot_n = bn;
    stby = 1'b1; remap_we = 1'b1; remap_sel = 2'b11;
    @(negedge clk); stby = 1'b0; remap_we = 1'b0;
    cur_std = exp_sel(p, ub, sn, bn, empty_m);
    cur_shr = exp_sel(pin_rst, ub, sn, bn, empty_m);
    chk("R5 R8 standby std", {30'b0, sel_std}, {30'b0, cur_std});
    chk("R6 standby shr", {30'b0, sel_shr}, {30'b0, cur_shr});
  endtask

  task automatic idle_check(int cyc);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      pin = 1'($urandom); use_bit = 1'($urandom);
      sys_n = 1'($urandom); boot_n = 1'($urandom);
    end
    @(negedge clk);
    chk("R11 hold std", {30'b0, sel_std}, {30'b0, cur_std});
    chk("R11 hold shr", {30'b0, sel_shr}, {30'b0, cur_shr});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk);
    chk("R7 empty after por", {31'b0, empty_std}, 32'h0);
    por_ni = 1'b1;
    // directed corners
    load_opt(32'h0);
    boot(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);     // flash by pin, empty -> system (R8)
    boot(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);     // pin 1, SRAM (R2)
    load_opt(32'h0000_0100);
    idle_check(3);                          // empty change alone: no effect (R11)
    boot(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);     // variants disagree (R6)
    boot(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);     // option bit flash, pin ignored (R3)
    boot(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);     // option bit SRAM (R3)
    remap(2'b10);                           // reserved ignored (R1, R9)
    remap(2'b01);
    stby_exit(1'b1, 1'b0, 1'b1, 1'b1);
    // random mix
    for (int it = 0; it < 60; it++) begin
      if ($urandom_range(3) == 0) load_opt(($urandom_range(1) == 0) ? 32'h0 : $urandom | 32'h1);
      boot(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      remap(2'($urandom));
      idle_check($urandom_range(1, 4));
      stby_exit(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      idle_check(1);
    end
    summary();
    $finish;
  end
endmodule